// File: doc/BRIEF.md
# Redundant Receiver Arbitration Logic

This block arbitrates between three redundant copies of one received frame. A differential-style bus is sensed by three receivers: one on the high wire, one on the low wire and one on the sum of the two. For each frame, upstream logic delivers three data words and one CRC-valid flag per receiver, and pulses a frame-done strobe. On that strobe the block captures everything. It compares the captured words pairwise for full-word equality and picks which word goes to each of its two output slots. It also raises an error flag when the copies cannot be reconciled.

The selection rule is fault tolerant. When one wire's CRC fails, the sum receiver's word can stand in for that wire's word. This substitution happens only if the sum word matches the surviving wire's word bit for bit. When both wires fail but the sum survives (common-mode noise), the sum word fills both slots. In every other failing case the slots fall back to the high and low words and the error flag is set. The result is registered and held until the next frame, and a one-cycle valid pulse marks each update.

Top module: `rra_arbiter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `err_flag`, `slot0_data` and `slot1_data` are all zero.
- R2: A `frame_done` sampled high at clock edge k makes `out_valid` high for exactly the cycle following edge k+1, with the new slot data and error flag visible from that edge onward. Back-to-back strobes give back-to-back updates.
- R3: With all three CRC flags valid and the high word equal to the low word, `err_flag` is 0, slot 0 carries the high word and slot 1 carries the low word.
- R4: With all three CRC flags valid and the high and low words different, `err_flag` is 1, slot 0 carries the high word and slot 1 carries the low word.
- R5: With only the low CRC invalid: if the high and sum words match, `err_flag` is 0, slot 0 carries high and slot 1 carries sum; otherwise `err_flag` is 1 and the slots carry high and low.
- R6: With only the high CRC invalid: if the low and sum words match, `err_flag` is 0, slot 0 carries sum and slot 1 carries low; otherwise `err_flag` is 1 and the slots carry high and low.
- R7: With high and low CRCs invalid and the sum CRC valid, `err_flag` is 0 and both slots carry the sum word.
- R8: With all three CRCs invalid, `err_flag` is 1, slot 0 carries high and slot 1 carries low.
- R9: Any other flag combination (only sum invalid, or sum invalid with exactly one wire valid) is resolved as in R3/R4 by the high/low comparison.
- R10: Word comparison covers every bit: a difference in any single bit position, including bit 0 and the top bit, counts as a mismatch.
- R11: Changes on the data and CRC inputs while `frame_done` is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: frame complete, capture inputs |
| crc_ok_hi | input | 1 | CRC valid from the high-wire receiver |
| crc_ok_lo | input | 1 | CRC valid from the low-wire receiver |
| crc_ok_sum | input | 1 | CRC valid from the sum receiver |
| data_hi | input | WIDTH | Data word from the high-wire receiver |
| data_lo | input | WIDTH | Data word from the low-wire receiver |
| data_sum | input | WIDTH | Data word from the sum receiver |
| slot0_data | output | WIDTH | Selected data for output slot 0 |
| slot1_data | output | WIDTH | Selected data for output slot 1 |
| err_flag | output | 1 | Frame could not be reconciled |
| out_valid | output | 1 | One-cycle pulse marking an update of the slots and flag |

## Verification
A strobe sampled at edge k is captured at that edge, and the verdict is registered at edge k+1. The slots, error flag and valid pulse are therefore due in the cycle after edge k+1 and hold after it. The bench reference model queues every strobe with its capture cycle and releases it one edge later. The bench compares all four outputs with the model at every falling edge, away from the edges where they change. In cycles with no update, the model holds its previous values, so any reaction to inputs that change between strobes shows up as a mismatch.

// File: rtl/rra_pkg.sv
package rra_pkg;

  // receiver indices, fixed by the decision table
  localparam int RX_HI   = 0;
  localparam int RX_LO   = 1;
  localparam int RX_SUM  = 2;
  localparam int NUM_RX  = 3;
  localparam int NUM_CMP = 3;

  // comparator pair indices
  localparam int CMP_HL = 0;
  localparam int CMP_HS = 1;
  localparam int CMP_LS = 2;

  typedef enum logic [1:0] {
    SRC_HI  = 2'd0,
    SRC_LO  = 2'd1,
    SRC_SUM = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    FC_NORMAL = 3'd0,
    FC_LO_BAD = 3'd1,
    FC_HI_BAD = 3'd2,
    FC_COMMON = 3'd3,
    FC_ALLBAD = 3'd4
  } fcase_e;

  typedef struct packed {
    logic err;
    src_e sel0;
    src_e sel1;
  } verdict_t;

  function automatic int cmp_a(input int p);
    return (p == CMP_LS) ? RX_LO : RX_HI;
  endfunction

  function automatic int cmp_b(input int p);
    return (p == CMP_HL) ? RX_LO : RX_SUM;
  endfunction

endpackage

// File: rtl/rra_capture.sv
module rra_capture
  import rra_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          strobe,
  input  logic [NUM_RX-1:0]             ok_in,
  input  logic [NUM_RX-1:0][WIDTH-1:0]  data_in,
  output logic [NUM_RX-1:0]             ok_q,
  output logic [NUM_RX-1:0][WIDTH-1:0]  data_q,
  output logic                          pend_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= strobe;
    end
  end

  for (genvar r = 0; r < NUM_RX; r++) begin : g_rx
    always_ff @(posedge clk) begin
      if (rst) begin
        ok_q[r]   <= 1'b0;
        data_q[r] <= '0;
      end else if (strobe) begin
        ok_q[r]   <= ok_in[r];
        data_q[r] <= data_in[r];
      end
    end
  end

endmodule

// File: rtl/rra_compare.sv
module rra_compare
  import rra_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [NUM_RX-1:0][WIDTH-1:0] data,
  output logic [NUM_CMP-1:0]           eq
);

  for (genvar p = 0; p < NUM_CMP; p++) begin : g_pair
    localparam int IA = cmp_a(p);
    localparam int IB = cmp_b(p);
    logic [WIDTH-1:0] diff;
    always_comb begin
      diff  = data[IA] ^ data[IB];
      eq[p] = ~|diff;
    end
  end

endmodule

// File: rtl/rra_decide.sv
module rra_decide
  import rra_pkg::*;
(
  input  logic [NUM_RX-1:0]  ok,
  input  logic [NUM_CMP-1:0] eq,
  output verdict_t           verdict
);

  fcase_e fcase;

  always_comb begin
    unique case ({ok[RX_HI], ok[RX_LO], ok[RX_SUM]})
      3'b101:  fcase = FC_LO_BAD;
      3'b011:  fcase = FC_HI_BAD;
      3'b001:  fcase = FC_COMMON;
      3'b000:  fcase = FC_ALLBAD;
      default: fcase = FC_NORMAL;
    endcase
  end

  always_comb begin
    verdict = '{err: 1'b1, sel0: SRC_HI, sel1: SRC_LO};
    unique case (fcase)
      FC_NORMAL: verdict.err = ~eq[CMP_HL];
      FC_LO_BAD: if (eq[CMP_HS]) verdict = '{err: 1'b0, sel0: SRC_HI,  sel1: SRC_SUM};
      FC_HI_BAD: if (eq[CMP_LS]) verdict = '{err: 1'b0, sel0: SRC_SUM, sel1: SRC_LO};
      FC_COMMON: verdict = '{err: 1'b0, sel0: SRC_SUM, sel1: SRC_SUM};
      default:   verdict.err = 1'b1;
    endcase
  end

endmodule

// File: rtl/rra_outreg.sv
module rra_outreg
  import rra_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  verdict_t                     verdict,
  input  logic [NUM_RX-1:0][WIDTH-1:0] data,
  output logic [WIDTH-1:0]             slot0,
  output logic [WIDTH-1:0]             slot1,
  output logic                         err,
  output logic                         valid
);

  function automatic logic [WIDTH-1:0] pick(input src_e s,
                                            input logic [NUM_RX-1:0][WIDTH-1:0] d);
    unique case (s)
      SRC_LO:  return d[RX_LO];
      SRC_SUM: return d[RX_SUM];
      default: return d[RX_HI];
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      slot0 <= '0;
      slot1 <= '0;
      err   <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) begin
        slot0 <= pick(verdict.sel0, data);
        slot1 <= pick(verdict.sel1, data);
        err   <= verdict.err;
      end
    end
  end

endmodule

// File: rtl/rra_arbiter.sv
module rra_arbiter
  import rra_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_done,
  input  logic             crc_ok_hi,
  input  logic             crc_ok_lo,
  input  logic             crc_ok_sum,
  input  logic [WIDTH-1:0] data_hi,
  input  logic [WIDTH-1:0] data_lo,
  input  logic [WIDTH-1:0] data_sum,
  output logic [WIDTH-1:0] slot0_data,
  output logic [WIDTH-1:0] slot1_data,
  output logic             err_flag,
  output logic             out_valid
);

  logic [NUM_RX-1:0]             ok_in;
  logic [NUM_RX-1:0][WIDTH-1:0]  data_in;
  logic [NUM_RX-1:0]             ok_q;
  logic [NUM_RX-1:0][WIDTH-1:0]  data_q;
  logic                          pend_q;
  logic [NUM_CMP-1:0]            eq;
  verdict_t                      verdict;

  always_comb begin
    ok_in[RX_HI]    = crc_ok_hi;
    ok_in[RX_LO]    = crc_ok_lo;
    ok_in[RX_SUM]   = crc_ok_sum;
    data_in[RX_HI]  = data_hi;
    data_in[RX_LO]  = data_lo;
    data_in[RX_SUM] = data_sum;
  end

  rra_capture #(.WIDTH(WIDTH)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .strobe  (frame_done),
    .ok_in   (ok_in),
    .data_in (data_in),
    .ok_q    (ok_q),
    .data_q  (data_q),
    .pend_q  (pend_q)
  );

  rra_compare #(.WIDTH(WIDTH)) u_cmp (
    .data (data_q),
    .eq   (eq)
  );

  rra_decide u_dec (
    .ok      (ok_q),
    .eq      (eq),
    .verdict (verdict)
  );

  rra_outreg #(.WIDTH(WIDTH)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (pend_q),
    .verdict (verdict),
    .data    (data_q),
    .slot0   (slot0_data),
    .slot1   (slot1_data),
    .err     (err_flag),
    .valid   (out_valid)
  );

endmodule

// File: rtl/rra_arbiter_chk.sv
module rra_arbiter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_done,
  input logic             crc_ok_hi,
  input logic             crc_ok_lo,
  input logic             crc_ok_sum,
  input logic [WIDTH-1:0] data_hi,
  input logic [WIDTH-1:0] data_lo,
  input logic [WIDTH-1:0] data_sum,
  input logic [WIDTH-1:0] slot0_data,
  input logic [WIDTH-1:0] slot1_data,
  input logic             err_flag,
  input logic             out_valid
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && !err_flag && slot0_data == '0 && slot1_data == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ##2 out_valid); // R2

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$stable(slot0_data) || !$stable(slot1_data) || !$stable(err_flag)) |-> out_valid); // R11

  AST_CLEAN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (frame_done && crc_ok_hi && crc_ok_lo && crc_ok_sum && data_hi == data_lo) |-> ##2
    (!err_flag && slot0_data == $past(data_hi, 2) && slot1_data == $past(data_lo, 2))); // R3

  AST_LO_BAD_SUB: assert property (@(posedge clk) disable iff (rst)
    (frame_done && crc_ok_hi && !crc_ok_lo && crc_ok_sum && data_hi == data_sum) |-> ##2
    (!err_flag && slot0_data == $past(data_hi, 2) && slot1_data == $past(data_sum, 2))); // R5

  AST_HI_BAD_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !crc_ok_hi && crc_ok_lo && crc_ok_sum && data_lo != data_sum) |-> ##2
    (err_flag && slot0_data == $past(data_hi, 2) && slot1_data == $past(data_lo, 2))); // R6

  AST_COMMON_MODE: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !crc_ok_hi && !crc_ok_lo && crc_ok_sum) |-> ##2
    (!err_flag && slot0_data == $past(data_sum, 2) && slot1_data == $past(data_sum, 2))); // R7

  AST_ALL_BAD: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !crc_ok_hi && !crc_ok_lo && !crc_ok_sum) |-> ##2
    (err_flag && slot0_data == $past(data_hi, 2) && slot1_data == $past(data_lo, 2))); // R8

endmodule

bind rra_arbiter rra_arbiter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_done (frame_done),
  .crc_ok_hi  (crc_ok_hi),
  .crc_ok_lo  (crc_ok_lo),
  .crc_ok_sum (crc_ok_sum),
  .data_hi    (data_hi),
  .data_lo    (data_lo),
  .data_sum   (data_sum),
  .slot0_data (slot0_data),
  .slot1_data (slot1_data),
  .err_flag   (err_flag),
  .out_valid  (out_valid)
);

// File: tb/rra_arbiter_tb.sv
module rra_arbiter_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_done = 1'b0;
  logic         ok_h = 1'b0, ok_l = 1'b0, ok_s = 1'b0;
  logic [W-1:0] d_h = '0, d_l = '0, d_s = '0;
  logic [W-1:0] slot0, slot1;
  logic         err, vld;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_tag = "";

  typedef struct {
    int           at;
    logic         err;
    logic [W-1:0] s0;
    logic [W-1:0] s1;
    string        tag;
  } exp_t;

  exp_t         q[$];
  logic         m_vld = 1'b0, m_err = 1'b0;
  logic [W-1:0] m_s0 = '0, m_s1 = '0;
  string        m_tag = "R1";

  always #5 clk = ~clk;

  rra_arbiter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .frame_done(frame_done),
    .crc_ok_hi(ok_h), .crc_ok_lo(ok_l), .crc_ok_sum(ok_s),
    .data_hi(d_h), .data_lo(d_l), .data_sum(d_s),
    .slot0_data(slot0), .slot1_data(slot1), .err_flag(err), .out_valid(vld)
  );

  // behavioural statement of R3..R9 (R10: equality is whole-word)
  function automatic exp_t ref_decide(input logic h, input logic l, input logic s,
                                      input logic [W-1:0] a, input logic [W-1:0] b,
                                      input logic [W-1:0] c);
    exp_t e;
    e.at = 0; e.err = 1'b1; e.s0 = a; e.s1 = b;
    if (h && l && s) begin
      e.err = (a != b); e.tag = (a == b) ? "R3" : "R4";
    end else if (h && !l && s) begin
      e.tag = "R5";
      if (a == c) begin e.err = 1'b0; e.s1 = c; end
    end else if (!h && l && s) begin
      e.tag = "R6";
      if (b == c) begin e.err = 1'b0; e.s0 = c; end
    end else if (!h && !l && s) begin
      e.tag = "R7"; e.err = 1'b0; e.s0 = c; e.s1 = c;
    end else if (!h && !l && !s) begin
      e.tag = "R8";
    end else begin
      e.tag = "R9"; e.err = (a != b);
    end
    return e;
  endfunction

  // reference model: a strobe at edge k is released at edge k+1 (R2)
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      q.delete();
      m_vld = 1'b0; m_err = 1'b0; m_s0 = '0; m_s1 = '0; m_tag = "R1";
    end else begin
      m_vld = 1'b0;
      m_tag = "R2/R11";
      if (q.size() > 0 && q[0].at == cyc - 1) begin
        exp_t e;
        e = q.pop_front();
        m_vld = 1'b1; m_err = e.err; m_s0 = e.s0; m_s1 = e.s1; m_tag = e.tag;
      end
      if (frame_done) begin
        exp_t e;
        e = ref_decide(ok_h, ok_l, ok_s, d_h, d_l, d_s);
        e.at = cyc;
        if (cur_tag != "") e.tag = cur_tag;
        q.push_back(e);
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // compare on every clock at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check(m_tag, "out_valid", W'(vld), W'(m_vld));
      check(m_tag, "err_flag", W'(err), W'(m_err));
      check(m_tag, "slot0", slot0, m_s0);
      check(m_tag, "slot1", slot1, m_s1);
    end
  end

  task automatic frame(input logic h, input logic l, input logic s,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input string tag);
    @(negedge clk);
    ok_h = h; ok_l = l; ok_s = s; d_h = a; d_l = b; d_s = c;
    cur_tag = tag; frame_done = 1'b1;
  endtask

  // R11: scramble inputs with no strobe
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_done = 1'b0;
      ok_h = 1'($urandom); ok_l = 1'($urandom); ok_s = 1'($urandom);
      d_h = W'($urandom); d_l = W'($urandom); d_s = W'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid in reset", W'(vld), '0);
    check("R1", "err_flag in reset", W'(err), '0);
    check("R1", "slot0 in reset", slot0, '0);
    check("R1", "slot1 in reset", slot1, '0);
    rst = 1'b0;
    idle(3);
    frame(1, 1, 1, 16'h1234, 16'h1234, 16'h1234, "R3"); idle(4);
    frame(1, 1, 1, 16'h1234, 16'h1235, 16'h1234, "R4"); idle(3);
    frame(1, 0, 1, 16'hA5A5, 16'h0000, 16'hA5A5, "R5"); idle(3);
    frame(1, 0, 1, 16'hA5A5, 16'h0F0F, 16'hA5A4, "R5"); idle(3);
    frame(0, 1, 1, 16'h0001, 16'h7777, 16'h7777, "R6"); idle(3);
    frame(0, 1, 1, 16'h0001, 16'h7777, 16'h7776, "R6"); idle(3);
    frame(0, 0, 1, 16'h1111, 16'h2222, 16'hBEEF, "R7"); idle(3);
    frame(0, 0, 0, 16'h1111, 16'h2222, 16'hBEEF, "R8"); idle(3);
    frame(1, 1, 0, 16'hC0DE, 16'hC0DE, 16'h0000, "R9"); idle(2);
    frame(1, 0, 0, 16'hC0DE, 16'hC0DF, 16'hC0DE, "R9"); idle(2);
    frame(0, 1, 0, 16'h4444, 16'h4444, 16'h9999, "R9"); idle(2);
    // R10: single-bit differences at the low and top positions
    frame(1, 1, 1, 16'h8000, 16'h0000, 16'h0000, "R10");
    frame(1, 0, 1, 16'h0001, 16'h0000, 16'h0000, "R10");
    frame(0, 1, 1, 16'h0000, 16'h8000, 16'h0000, "R10");
    frame(0, 1, 1, 16'hFFFF, 16'hFFFE, 16'hFFFE, "R10");
    idle(3);
    // R2: random traffic with back-to-back and spaced strobes
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] base;
      base = W'($urandom);
      frame(1'($urandom), 1'($urandom), 1'($urandom), base,
            ($urandom_range(0, 1) != 0) ? base : base ^ W'(1 << $urandom_range(0, W - 1)),
            ($urandom_range(0, 2) != 0) ? base : W'($urandom), "");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule